// File: doc/BRIEF.md
# T1 Receive Data Link Extractor

This block sits after a T1 receive framer that has already found frame alignment. It watches the 1.544 MHz aligned bit stream and picks out the framing-position bits that carry the overhead data link. It presents them one at a time on a serial link output, together with a link clock. The framing mode chooses which framing positions make up the link. In extended-superframe mode the link is the facility data link. In superframe mode it is the signalling-framing bits. In zero-byte time-slot-interchange mode it is the Z bits, which arrive at half the rate.

The framer upstream gives a pulse on the framing bit of each 193-bit frame and the index of that frame within the multiframe. The block captures the framing bit when that pulse arrives. It then drives the bit onto the link output on the last bit of the same frame, which is one line-clock period before the next frame starts. The link clock is high for the frame period that follows a link bit. It stays low after a frame that carries no link bit. This gives 4 kHz in the extended-superframe and superframe modes and 2 kHz in the Z-bit mode. All timing comes from the single receive line clock.

Top module: `t1_dlink_rx`

## Requirements
- R1: While rst_ni is low, and after its release until the first link bit, both data_o and lclk_o are 0.
- R2: With mode_i = 2'b00 (extended superframe), a frame is a link frame when frm_idx_i, sampled with frm_start_i, is even (frame numbers 1, 3, ... 23 counted from 1).
- R3: With mode_i = 2'b01 (superframe), a frame is a link frame when frm_idx_i is odd and below 12 (even frame numbers of the 12-frame superframe).
- R4: With mode_i = 2'b10 (Z bits), a frame is a link frame when frm_idx_i is a multiple of 4, so the link runs at half the rate.
- R5: With mode_i = 2'b11, no frame is a link frame: lclk_o stays 0 and data_o keeps its value.
- R6: The bit that ser_i carries in the frm_start_i cycle of a link frame appears on data_o starting with bit position 192 of that frame. This is one clock before the next frame start. Both outputs keep their old values up to and including position 191.
- R7: At position 192 of each frame, lclk_o becomes 1 if that frame was a link frame and 0 if it was not. It then holds that value for the rest of the frame period.
- R8: data_o keeps its last value between link bits and changes only together with a rising link clock.
- R9: Only the framing bit (position 0) is sampled; payload bits at positions 1 to 192 have no effect on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive line clock, 1.544 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Aligned receive serial data |
| frm_start_i | input | 1 | High during the framing bit (position 0) of each frame |
| frm_idx_i | input | 5 | Frame index within the multiframe, 0-based, valid with frm_start_i |
| mode_i | input | 2 | 00 extended superframe, 01 superframe, 10 Z bits, 11 link off |
| data_o | output | 1 | Serial link data |
| lclk_o | output | 1 | Link clock |

## Verification
Every result of a frame is due in a single cycle: position 192 of that frame. Position 192 follows the clock edge that ends position 191, so the result comes one register stage after that edge and 192 cycles after the framing bit was captured. The bench drives each bit at the falling edge. Before it drives the next bit, it samples the outputs at positions 100 and 191, where the old values must still hold, and at position 192, where the new values must have arrived. The expected values come from the frame index, the mode and the framing bit the bench itself sent.

// File: rtl/t1_dlink_pkg.sv
package t1_dlink_pkg;
  typedef enum logic [1:0] {
    MODE_ESF = 2'b00,
    MODE_SF  = 2'b01,
    MODE_ZB  = 2'b10,
    MODE_OFF = 2'b11
  } dl_mode_e;

  localparam int unsigned FRAME_BITS = 193;
  localparam int unsigned MF_FRAMES  = 24;
  localparam int unsigned SF_FRAMES  = 12;
  localparam int unsigned ZB_STRIDE  = 4;
endpackage

// File: rtl/t1_dlink_bit_pos.sv
module t1_dlink_bit_pos #(
  parameter int unsigned FRAME_BITS = t1_dlink_pkg::FRAME_BITS,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frm_start_i,
  output logic tick_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] PRE_POS  = CNT_W'(FRAME_BITS - 2);

  logic [CNT_W-1:0] cnt_q, pos;

  assign pos    = frm_start_i ? '0 : cnt_q;
  // register update lands on the last bit position of the frame
  assign tick_o = (pos == PRE_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (pos == LAST_POS) cnt_q <= '0;
    else                      cnt_q <= pos + 1'b1;
  end
endmodule

// File: rtl/t1_dlink_slot_sel.sv
module t1_dlink_slot_sel #(
  parameter int unsigned MF_FRAMES = t1_dlink_pkg::MF_FRAMES,
  parameter int unsigned SF_FRAMES = t1_dlink_pkg::SF_FRAMES,
  parameter int unsigned ZB_STRIDE = t1_dlink_pkg::ZB_STRIDE,
  localparam int unsigned FRM_W    = $clog2(MF_FRAMES)
) (
  input  t1_dlink_pkg::dl_mode_e mode_i,
  input  logic [FRM_W-1:0]       frm_idx_i,
  output logic                   slot_o
);
  import t1_dlink_pkg::*;

  logic esf_slot, sf_slot, zb_slot;

  assign esf_slot = ~frm_idx_i[0];
  assign sf_slot  = frm_idx_i[0] && (frm_idx_i < FRM_W'(SF_FRAMES));

  generate
    if ((ZB_STRIDE & (ZB_STRIDE - 1)) == 0 && ZB_STRIDE > 1) begin : g_zb_pow2
      localparam int unsigned ZW = $clog2(ZB_STRIDE);
      assign zb_slot = (frm_idx_i[ZW-1:0] == '0);
    end else begin : g_zb_mod
      assign zb_slot = ((32'(frm_idx_i) % ZB_STRIDE) == 0);
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MODE_ESF: slot_o = esf_slot;
      MODE_SF:  slot_o = sf_slot;
      MODE_ZB:  slot_o = zb_slot;
      default:  slot_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/t1_dlink_out_stage.sv
module t1_dlink_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic slot_i,
  input  logic bit_i,
  input  logic tick_i,
  output logic data_o,
  output logic lclk_o
);
  logic pend_vld_q, pend_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_bit_q <= 1'b0;
    end else if (cap_i) begin
      pend_vld_q <= slot_i;
      pend_bit_q <= bit_i;
    end else if (tick_i) begin
      pend_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
      lclk_o <= 1'b0;
    end else if (tick_i) begin
      lclk_o <= pend_vld_q;
      if (pend_vld_q) data_o <= pend_bit_q;
    end
  end
endmodule

// File: rtl/t1_dlink_rx.sv
module t1_dlink_rx #(
  parameter int unsigned FRAME_BITS = t1_dlink_pkg::FRAME_BITS,
  parameter int unsigned MF_FRAMES  = t1_dlink_pkg::MF_FRAMES,
  localparam int unsigned FRM_W     = $clog2(MF_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             frm_start_i,
  input  logic [FRM_W-1:0] frm_idx_i,
  input  logic [1:0]       mode_i,
  output logic             data_o,
  output logic             lclk_o
);
  logic tick, slot;

  t1_dlink_bit_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frm_start_i (frm_start_i),
    .tick_o      (tick)
  );

  t1_dlink_slot_sel #(.MF_FRAMES(MF_FRAMES)) u_sel (
    .mode_i    (t1_dlink_pkg::dl_mode_e'(mode_i)),
    .frm_idx_i (frm_idx_i),
    .slot_o    (slot)
  );

  t1_dlink_out_stage u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (frm_start_i),
    .slot_i (slot),
    .bit_i  (ser_i),
    .tick_i (tick),
    .data_o (data_o),
    .lclk_o (lclk_o)
  );
endmodule

// File: rtl/t1_dlink_rx_chk.sv
module t1_dlink_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frm_start_i,
  input logic data_o,
  input logic lclk_o
);
  // R1: outputs cleared while in reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (data_o == 1'b0 && lclk_o == 1'b0)
        else $error("reset value wrong");
    end
  end

  assert_data_pre_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |=> frm_start_i);

  assert_lclk_pre_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lclk_o) |=> frm_start_i);

  assert_lclk_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_i |-> $stable(lclk_o));

  assert_data_with_lclk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> lclk_o);
endmodule

bind t1_dlink_rx t1_dlink_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frm_start_i (frm_start_i),
  .data_o      (data_o),
  .lclk_o      (lclk_o)
);

// File: tb/t1_dlink_rx_tb_top.sv
`timescale 1ns/1ps
module t1_dlink_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser = 1'b0;
  logic       fstart = 1'b0;
  logic [4:0] fidx = '0;
  logic [1:0] mode = '0;
  logic       data, lclk;

  int n_run = 0;
  int n_fail = 0;
  logic exp_d = 1'b0;
  logic exp_l = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  t1_dlink_rx dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ser_i       (ser),
    .frm_start_i (fstart),
    .frm_idx_i   (fidx),
    .mode_i      (mode),
    .data_o      (data),
    .lclk_o      (lclk)
  );

  function automatic bit is_link(input logic [1:0] m, input int idx);
    case (m)
      2'b00:   return (idx % 2) == 0;
      2'b01:   return ((idx % 2) == 1) && (idx < 12);
      2'b10:   return (idx % 4) == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // pay: 0 random payload, 1 all ones, 2 all zeros
  task automatic run_frame(input logic [1:0] m, input int idx, input logic fbit,
                           input int pay, input string tag);
    bit lk;
    lk = is_link(m, idx);
    for (int b = 0; b < 193; b++) begin
      @(negedge clk);
      if (b == 100) begin
        chk(data, exp_d, "R8", "data mid-frame hold");
        chk(lclk, exp_l, "R7", "lclk mid-frame hold");
      end
      if (b == 191) begin
        chk(data, exp_d, "R6", "data before update");
        chk(lclk, exp_l, "R6", "lclk before update");
      end
      if (b == 192) begin
        exp_l = lk;
        if (lk) exp_d = fbit;
        chk(data, exp_d, (tag == "") ? mode_tag(m) : tag, "data at position 192");
        chk(lclk, exp_l, "R7", "lclk at position 192");
      end
      mode   = m;
      fidx   = 5'(idx);
      fstart = (b == 0);
      if (b == 0)        ser = fbit;
      else if (pay == 1) ser = 1'b1;
      else if (pay == 2) ser = 1'b0;
      else               ser = 1'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd1544));
    repeat (4) @(negedge clk);
    chk(data, 1'b0, "R1", "data in reset");
    chk(lclk, 1'b0, "R1", "lclk in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(data, 1'b0, "R1", "data after reset");
    chk(lclk, 1'b0, "R1", "lclk after reset");

    // R9: framing bit 0 amid all-ones payload, then 1 amid zeros
    run_frame(2'b00, 0, 1'b0, 1, "R9");
    run_frame(2'b00, 1, 1'b1, 1, "R9");
    run_frame(2'b00, 2, 1'b1, 2, "R9");
    run_frame(2'b00, 3, 1'b0, 1, "R9");
    // R2: full extended multiframe, alternating framing bits
    for (int f = 0; f < 24; f++) run_frame(2'b00, f, 1'(f / 2), 0, "");
    // R3: superframe
    for (int f = 0; f < 12; f++) run_frame(2'b01, f, 1'(f / 3), 0, "");
    // R4: Z-bit mode, half rate
    for (int f = 0; f < 24; f++) run_frame(2'b10, f, 1'(f / 4), 0, "");
    // R5: link off, payload and framing bits must not reach data_o
    run_frame(2'b00, 0, 1'b1, 0, "R2");
    for (int f = 0; f < 6; f++) run_frame(2'b11, f, 1'b0, 1, "R5");

    // constrained random: whole multiframes in random modes
    for (int k = 0; k < 8; k++) begin
      logic [1:0] m;
      int lim;
      m   = 2'($urandom_range(0, 3));
      lim = (m == 2'b01) ? 12 : 24;
      for (int f = 0; f < lim; f++) run_frame(m, f, 1'($urandom), 0, "");
    end

    @(negedge clk);
    fstart = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule